// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block picks one of several free-running clock inputs and passes it to a single system clock output. A 2-bit select input names the wanted source. When the select names a different source, the block first shuts the old clock off and then lets the new one through. The output is held low between the two, so no high or low phase ever comes out shorter than a real half-period of one of the inputs.

Each source has its own enable flop, which only changes while its own clock is low. An enable is dropped after a short synchronizer in the old clock's domain. The new enable is raised only after that synchronizer in the new domain has seen every other enable off. The select is sampled on rising edges of the output clock. Because that clock is stopped or still on its old source during a handover, a select change made mid-switch is held back and starts the next switch once the current one has finished. A busy output stays high for the whole handover. All inputs are assumed running and stable; start-up qualification of a source is handled elsewhere.

Top module: `clksw_top`

## Requirements
- R1: While reset is asserted and after it is released, the output follows source 0 and busy is low.
- R2: While no switch is in progress, the output equals, level for level, the clock of the most recently completed selection, and at most one source enable is ever on.
- R3: The select is sampled on rising edges of the output. When it differs from the current source, the output then delivers exactly two further rising edges of the old source before going low.
- R4: After the old source's last passed falling edge, the output stays low until the fourth rising edge of the new source, which is the first one passed. The new-source part of the pause therefore lasts between three and four of its periods.
- R5: No high or low phase of the output is shorter than the shortest half-period among the sources.
- R6: Busy goes high right after the output edge that sampled a differing select, and goes low right after the first passed rising edge of the new source.
- R7: A select equal to the current source starts no switch: busy stays low and the output keeps running without a pause.
- R8: Select changes made while busy is high do not disturb the switch in progress. The value present at the first output rising edge after busy falls starts the next switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | NSRC | Free-running source clocks; bit i is source i |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | SEL_W | Wanted source number (2 bits by default) |
| clk_out | output | 1 | Selected, glitch-free system clock |
| busy | output | 1 | High while a handover is in progress |

## Verification
Busy is due on the same output edge that samples the select, so the bench looks at it one picosecond after that edge. The two old-source edges of R3 are counted as the next two output rising edges. The new-source wait of R4 is measured by taking a snapshot of a per-source rising-edge counter just after the output's final falling edge, then reading it again just after the next output rising edge, where exactly four new edges are expected and busy must already read low. Level-for-level following (R2) is compared a fraction of a nanosecond after every edge of the fastest source whenever the bench's own model says no switch is pending, and a monitor times every output phase for R5.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  // Widest source count the helpers below accept.
  localparam int unsigned MAX_SRC = 16;

  // True when every enable except the one at position idx is off.
  function automatic logic others_quiet(input logic [MAX_SRC-1:0] en_vec,
                                        input int unsigned idx);
    logic [MAX_SRC-1:0] mask;
    mask = ~(MAX_SRC'(1) << idx);
    return (en_vec & mask) == '0;
  endfunction

  // Shift a new sample into the low end of a synchronizer word.
  function automatic logic [7:0] sync_shift(input logic [7:0] word,
                                            input logic sample);
    return {word[6:0], sample};
  endfunction

endpackage

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate
  import clksw_pkg::*;
#(
  parameter int unsigned IDX      = 0,
  parameter int unsigned SYNC_OFF = 2,
  parameter int unsigned SYNC_ON  = 3
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic want_i,   // target names this source (other domain)
  input  logic quiet_i,  // every other enable is off (other domains)
  output logic en_o,
  output logic gated_o
);

  localparam logic HOME = (IDX == 0);

  logic [7:0] want_s;
  logic [7:0] quiet_s;
  logic       want_seen;
  logic       quiet_seen;
  logic       en_q;

  // Rising-edge synchronizers in this source's own domain.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      want_s  <= {8{HOME}};
      quiet_s <= {8{HOME}};
    end else begin
      want_s  <= sync_shift(want_s, want_i);
      quiet_s <= sync_shift(quiet_s, quiet_i);
    end
  end

  assign want_seen  = want_s[SYNC_OFF-1];
  assign quiet_seen = quiet_s[SYNC_ON-1];

  // Enable moves only while this clock is low, so the AND below never chops a pulse.
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= HOME;
    else        en_q <= want_seen & quiet_seen;
  end

  assign en_o    = en_q;
  assign gated_o = clk_i & en_q;

  AST_SOLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_q |-> quiet_i);  // R2

  AST_GRANT_MATCHES_TARGET: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(en_q) |-> want_i);  // R4

endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_out,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-1:0]  en_i,
  output logic [SEL_W-1:0] tgt_o,
  output logic             busy_o
);

  logic [SEL_W-1:0] tgt_q;
  logic [SEL_W-1:0] cur_q;
  logic             busy;
  logic             sel_ok;
  logic             tgt_granted;

  assign busy        = (tgt_q != cur_q);
  assign sel_ok      = (int'(sel_i) < int'(NSRC));
  assign tgt_granted = en_i[tgt_q];

  // Runs on the output clock: it is frozen or still on the old source during a
  // handover, so a new select waits until the switch in progress completes.
  always_ff @(posedge clk_out or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      cur_q <= '0;
    end else if (!busy) begin
      if (sel_ok) tgt_q <= sel_i;
    end else if (tgt_granted) begin
      cur_q <= tgt_q;
    end
  end

  assign tgt_o  = tgt_q;
  assign busy_o = busy;

  AST_TARGET_HELD: assert property (@(posedge clk_out) disable iff (!rst_n)
    busy |=> $stable(tgt_q));  // R8

  AST_IDLE_OWNER: assert property (@(posedge clk_out) disable iff (!rst_n)
    !busy |-> en_i[cur_q]);  // R2

  AST_BUSY_ENDS_ON_GRANT: assert property (@(posedge clk_out) disable iff (!rst_n)
    $fell(busy) |-> en_i[cur_q]);  // R6

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter  int unsigned NSRC     = 4,
  parameter  int unsigned SYNC_OFF = 2,
  parameter  int unsigned SYNC_ON  = 3,
  localparam int unsigned SEL_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  clk_src,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_out,
  output logic             busy
);

  logic [NSRC-1:0]    en;
  logic [NSRC-1:0]    gated;
  logic [MAX_SRC-1:0] en_pad;
  logic [SEL_W-1:0]   tgt;

  assign en_pad  = MAX_SRC'(en);
  assign clk_out = |gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic want;
    logic quiet;
    assign want  = (tgt == SEL_W'(i));
    assign quiet = others_quiet(en_pad, i);

    clksw_gate #(
      .IDX      (i),
      .SYNC_OFF (SYNC_OFF),
      .SYNC_ON  (SYNC_ON)
    ) u_gate (
      .clk_i   (clk_src[i]),
      .rst_n   (rst_n),
      .want_i  (want),
      .quiet_i (quiet),
      .en_o    (en[i]),
      .gated_o (gated[i])
    );
  end

  clksw_ctrl #(
    .NSRC  (NSRC),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk_out (clk_out),
    .rst_n   (rst_n),
    .sel_i   (sel),
    .en_i    (en),
    .tgt_o   (tgt),
    .busy_o  (busy)
  );

  always_comb begin
    if (rst_n) begin
      AST_SINGLE_ENABLE: assert ($onehot0(en));  // R2
    end
  end

endmodule

// File: tb/clksw_top_test.sv
`timescale 1ns/1ps
module clksw_top_test;

  localparam real CLK_PERIOD = 10.0;
  localparam real P1 = 14.2, P2 = 6.6, P3 = 23.4;
  localparam real MIN_HALF = 3.3;
  localparam real WATCHDOG_NS = 1_000_000.0;

  logic c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic rst_n = 1;
  logic [1:0] sel = 0;
  logic clk_out, busy;
  wire [3:0] srcs = {c3, c2, c1, c0};

  clksw_top uut (.clk_src(srcs), .rst_n(rst_n), .sel(sel), .clk_out(clk_out), .busy(busy));

  initial forever #(CLK_PERIOD/2) c0 = ~c0;
  initial begin #1.13; forever #(P1/2) c1 = ~c1; end
  initial begin #2.71; forever #(P2/2) c2 = ~c2; end
  initial begin #4.37; forever #(P3/2) c3 = ~c3; end

  int cnt[4];
  always @(posedge c0) cnt[0]++;
  always @(posedge c1) cnt[1]++;
  always @(posedge c2) cnt[2]++;
  always @(posedge c3) cnt[3]++;

  int checks = 0, errors = 0;
  int exp_cur = 0;
  bit in_switch = 1;
  int runts = 0;
  realtime last_t = 0.0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $realtime, act, exp);
    end
  endtask

  // R5: time every output phase.
  always @(clk_out) begin
    if (rst_n && last_t > 0.0 && ($realtime - last_t) < MIN_HALF - 0.01) runts++;
    last_t = $realtime;
  end

  // R2: model says which source should be visible; compare after every fast edge.
  always @(posedge c2 or negedge c2) begin
    #0.2;
    if (rst_n && !in_switch)
      chk(clk_out === srcs[exp_cur], "R2 follow", int'(clk_out), int'(srcs[exp_cur]));
  end

  // Runs from just after the sampling edge to the first passed new edge.
  task automatic finish_switch(input int old, input int nw, input int late);
    int snap_o, snap_n;
    #0.001;
    snap_o = cnt[old];
    chk(busy === 1'b1, "R6 busy rises", int'(busy), 1);
    @(posedge clk_out); @(posedge clk_out); #0.001;
    chk(cnt[old] - snap_o == 2, "R3 two old edges", cnt[old] - snap_o, 2);
    chk(busy === 1'b1, "R6 busy held", int'(busy), 1);
    @(negedge clk_out); #0.001;
    snap_n = cnt[nw];
    if (late >= 0) sel = 2'(late);  // R8: change during the pause
    @(posedge clk_out); #0.001;
    chk(cnt[nw] - snap_n == 4, "R4 fourth new edge", cnt[nw] - snap_n, 4);
    chk(busy === 1'b0, "R6 busy falls", int'(busy), 0);
    exp_cur = nw;
    in_switch = 0;
  endtask

  task automatic switch_to(input int nw, input int late);
    int old = exp_cur;
    in_switch = 1;
    @(negedge clk_out); #0.05;
    sel = 2'(nw);
    @(posedge clk_out);
    finish_switch(old, nw, late);
  endtask

  initial begin
    #0.5 rst_n = 0;
    #60;
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    @(posedge c0); #0.2; chk(clk_out === 1'b1, "R1 high in reset", int'(clk_out), 1);
    @(negedge c0); #0.2; chk(clk_out === 1'b0, "R1 low in reset", int'(clk_out), 0);
    rst_n = 1;
    in_switch = 0;
    repeat (3) begin
      @(posedge c0); #0.2; chk(clk_out === 1'b1, "R1 follows source 0", int'(clk_out), 1);
    end
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);

    // R7: reselect the current source.
    @(negedge clk_out); #0.05; sel = 2'(exp_cur);
    repeat (12) begin
      @(posedge clk_out); #0.001;
      chk(busy === 1'b0, "R7 no switch", int'(busy), 0);
    end

    switch_to(1, -1);
    repeat (20) @(posedge c2);
    switch_to(2, -1);
    repeat (20) @(posedge c2);
    switch_to(3, -1);
    repeat (20) @(posedge c2);
    switch_to(0, -1);
    repeat (20) @(posedge c2);

    // R8: latched request 0 -> 2, then 1 requested mid-switch.
    switch_to(2, 1);
    in_switch = 1;
    @(posedge clk_out);
    finish_switch(2, 1, -1);
    chk(sel == 2'd1, "R8 latched value applied", exp_cur, 1);
    repeat (30) @(posedge c2);

    chk(runts == 0, "R5 no short phase", runts, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule